// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small accumulator machine. Each evaluation takes a primary operand, an optional second operand (the memory or temporary value), the current status byte and a 4-bit operation code. It returns an 8-bit result and a new status byte in the same evaluation. Surrounding control logic decides whether to write either of them back.

Each operation changes only the status bits it is defined to affect. Every other bit of the status byte is copied through unchanged. Compare and bit-test return the primary operand untouched and exist only for their flags. Subtract with borrow ignores the incoming carry, and its carry sense is the opposite of the one compare uses. Decimal arithmetic, register storage and instruction decoding belong to other blocks.

Top module: `alu8_core`

## Requirements
- R1: Status bit positions are negative N=bit 7, overflow V=bit 6, zero Z=bit 1, carry C=bit 0. Bits 5..2 of `flags_o` always equal bits 5..2 of `flags_i`.
- R2: Opcodes (`op_i`): AND=0x0, OR=0x1, XOR=0x2, ADC=0x3, SBC=0x4, INC=0x5, DEC=0x6, ASL=0x7, ROR=0x8, CMP=0x9, BIT=0xA, THA=0xB.
- R3: AND, OR and XOR return the bitwise result. They set N to result bit 7 and Z when the result is zero, and leave C and V as they were.
- R4: INC and DEC add or subtract one modulo 256 and set N and Z from the result. C and V are unchanged.
- R5: ASL shifts left, fills bit 0 with zero, puts the old bit 7 in C and sets N and Z from the result. V is unchanged.
- R6: ROR shifts right, fills bit 7 from the incoming C, puts the old bit 0 in C and sets N and Z from the result. V is unchanged.
- R7: ADC returns A+B+C. C is the carry out of bit 7 and V is two's-complement overflow. N and Z come from the result.
- R8: SBC returns A-B whatever the incoming C is. C=1 when no borrow occurs, V is two's-complement overflow of the subtraction, and N and Z come from the result.
- R9: CMP returns A unchanged. Z=1 when A equals B. C=1 when A<B unsigned and C=0 otherwise. N is bit 7 of A-B. V is unchanged.
- R10: BIT returns A unchanged. Z=1 when A AND B is zero, N takes B bit 7 and V takes B bit 6. C is unchanged.
- R11: THA returns A and leaves the whole status byte unchanged.
- R12: An opcode outside 0x0..0xB returns 0x00 and leaves the whole status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Primary operand |
| b_i | input | WIDTH | Second operand (ignored by unary operations) |
| flags_i | input | 8 | Current status byte |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Operation result |
| flags_o | output | 8 | Updated status byte |

## Verification
Whenever the inputs change, the assertions check the invariants that hold for a whole class of operations: the unnamed status bits pass through, THA and unknown codes leave the status byte unchanged, compare and bit-test echo A, and the logic and step operations keep C and V while Z follows the result. The exact arithmetic can only be shown by the bench's directed vectors. These cover carry and overflow out of ADC, the no-borrow sense of SBC with either incoming carry, the opposite carry sense of CMP, the rotate through carry and the wrap at the ends of INC and DEC.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 8;
  localparam int FLAG_N = 7;
  localparam int FLAG_V = 6;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_AND = 4'h0;
  localparam logic [OP_W-1:0] OP_ORA = 4'h1;
  localparam logic [OP_W-1:0] OP_EOR = 4'h2;
  localparam logic [OP_W-1:0] OP_ADC = 4'h3;
  localparam logic [OP_W-1:0] OP_SBC = 4'h4;
  localparam logic [OP_W-1:0] OP_INC = 4'h5;
  localparam logic [OP_W-1:0] OP_DEC = 4'h6;
  localparam logic [OP_W-1:0] OP_ASL = 4'h7;
  localparam logic [OP_W-1:0] OP_ROR = 4'h8;
  localparam logic [OP_W-1:0] OP_CMP = 4'h9;
  localparam logic [OP_W-1:0] OP_BIT = 4'hA;
  localparam logic [OP_W-1:0] OP_THA = 4'hB;

  // candidate flag values, also reused as per-flag update enables
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } nvzc_t;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_ARITH = 2'd2,
    GRP_SHIFT = 2'd3
  } grp_e;
endpackage

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o,
  output nvzc_t            fl_o,
  output nvzc_t            upd_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] and_w;
  assign and_w = a_i & b_i;

  always_comb begin
    res_o = '0;
    fl_o  = '0;
    upd_o = '0;
    unique case (op_i)
      OP_AND: begin res_o = and_w;     upd_o.n = 1'b1; upd_o.z = 1'b1; end
      OP_ORA: begin res_o = a_i | b_i; upd_o.n = 1'b1; upd_o.z = 1'b1; end
      OP_EOR: begin res_o = a_i ^ b_i; upd_o.n = 1'b1; upd_o.z = 1'b1; end
      OP_BIT: begin
        res_o   = a_i;
        upd_o.n = 1'b1;
        upd_o.v = 1'b1;
        upd_o.z = 1'b1;
      end
      default: ;
    endcase
    if (op_i == OP_BIT) begin
      fl_o.n = b_i[MSB];
      fl_o.v = b_i[MSB-1];
      fl_o.z = (and_w == '0);
    end else begin
      fl_o.n = res_o[MSB];
      fl_o.z = (res_o == '0);
    end
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o,
  output nvzc_t            fl_o,
  output nvzc_t            upd_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   add_w;
  logic [WIDTH:0]   sub_w;
  logic [WIDTH-1:0] one_w;

  assign one_w = {{(WIDTH-1){1'b0}}, 1'b1};
  // single carry chain shape: A + B + cin and A + ~B + 1
  assign add_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign sub_w = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};

  always_comb begin
    res_o = '0;
    fl_o  = '0;
    upd_o = '0;
    unique case (op_i)
      OP_ADC: begin
        res_o  = add_w[MSB:0];
        fl_o.c = add_w[WIDTH];
        fl_o.v = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
        upd_o  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
      end
      OP_SBC: begin
        res_o  = sub_w[MSB:0];
        fl_o.c = sub_w[WIDTH];
        fl_o.v = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
        upd_o  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
      end
      OP_CMP: begin
        res_o  = a_i;
        fl_o.c = ~sub_w[WIDTH];
        upd_o  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      OP_INC: begin
        res_o = a_i + one_w;
        upd_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      end
      OP_DEC: begin
        res_o = a_i - one_w;
        upd_o = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      end
      default: ;
    endcase
    if (op_i == OP_CMP) begin
      fl_o.n = sub_w[MSB];
      fl_o.z = (sub_w[MSB:0] == '0);
    end else begin
      fl_o.n = res_o[MSB];
      fl_o.z = (res_o == '0);
    end
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o,
  output nvzc_t            fl_o,
  output nvzc_t            upd_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o = '0;
    fl_o  = '0;
    upd_o = '0;
    unique case (op_i)
      OP_ASL: begin
        res_o  = {a_i[MSB-1:0], 1'b0};
        fl_o.c = a_i[MSB];
        upd_o  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      OP_ROR: begin
        res_o  = {cin_i, a_i[MSB:1]};
        fl_o.c = a_i[0];
        upd_o  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      default: ;
    endcase
    fl_o.n = res_o[MSB];
    fl_o.z = (res_o == '0);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] lg_res, ar_res, sh_res;
  nvzc_t            lg_fl, ar_fl, sh_fl;
  nvzc_t            lg_upd, ar_upd, sh_upd;
  nvzc_t            sel_fl, sel_upd;
  grp_e             grp;

  alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .res_o(lg_res), .fl_o(lg_fl), .upd_o(lg_upd)
  );

  alu8_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i(a_i), .b_i(b_i), .cin_i(flags_i[FLAG_C]), .op_i(op_i),
    .res_o(ar_res), .fl_o(ar_fl), .upd_o(ar_upd)
  );

  alu8_shifter #(.WIDTH(WIDTH)) u_shifter (
    .a_i(a_i), .cin_i(flags_i[FLAG_C]), .op_i(op_i),
    .res_o(sh_res), .fl_o(sh_fl), .upd_o(sh_upd)
  );

  // group decode
  always_comb begin
    unique case (op_i)
      OP_AND, OP_ORA, OP_EOR, OP_BIT:         grp = GRP_LOGIC;
      OP_ADC, OP_SBC, OP_CMP, OP_INC, OP_DEC: grp = GRP_ARITH;
      OP_ASL, OP_ROR:                         grp = GRP_SHIFT;
      default:                                grp = GRP_NONE;
    endcase
  end

  // result and flag select, then per-flag merge
  always_comb begin
    result_o = '0;
    sel_fl   = '0;
    sel_upd  = '0;
    unique case (grp)
      GRP_LOGIC: begin result_o = lg_res; sel_fl = lg_fl; sel_upd = lg_upd; end
      GRP_ARITH: begin result_o = ar_res; sel_fl = ar_fl; sel_upd = ar_upd; end
      GRP_SHIFT: begin result_o = sh_res; sel_fl = sh_fl; sel_upd = sh_upd; end
      default:   result_o = (op_i == OP_THA) ? a_i : '0;
    endcase
    flags_o = flags_i;
    if (sel_upd.n) flags_o[FLAG_N] = sel_fl.n;
    if (sel_upd.v) flags_o[FLAG_V] = sel_fl.v;
    if (sel_upd.z) flags_o[FLAG_Z] = sel_fl.z;
    if (sel_upd.c) flags_o[FLAG_C] = sel_fl.c;
  end

  // invariant checks, evaluated whenever inputs settle
  always_comb begin
    a_r1_spare_bits: assert (flags_o[5:2] == flags_i[5:2])
      else $error("R1 spare status bits altered");
    if (op_i == OP_THA)
      a_r11_tha_hold: assert (result_o == a_i && flags_o == flags_i)
        else $error("R11 THA changed data or flags");
    if (op_i > OP_THA)
      a_r12_unknown_op: assert (result_o == '0 && flags_o == flags_i)
        else $error("R12 unknown opcode not inert");
    if (op_i == OP_CMP || op_i == OP_BIT)
      a_r9_echo_a: assert (result_o == a_i)
        else $error("R9/R10 compare or bit test altered A");
    if (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR)
      a_r3_keep_cv: assert (flags_o[FLAG_C] == flags_i[FLAG_C] &&
                            flags_o[FLAG_V] == flags_i[FLAG_V] &&
                            flags_o[FLAG_Z] == (result_o == '0) &&
                            flags_o[FLAG_N] == result_o[MSB])
        else $error("R3 logic flag rule broken");
    if (op_i == OP_INC || op_i == OP_DEC)
      a_r4_keep_cv: assert (flags_o[FLAG_C] == flags_i[FLAG_C] &&
                            flags_o[FLAG_V] == flags_i[FLAG_V] &&
                            flags_o[FLAG_Z] == (result_o == '0))
        else $error("R4 step flag rule broken");
    if (op_i == OP_ROR)
      a_r6_rotate_in: assert (result_o[MSB] == flags_i[FLAG_C] &&
                              flags_o[FLAG_C] == a_i[0])
        else $error("R6 rotate through carry broken");
  end
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  localparam int W = 8;

  logic         clk;
  logic [W-1:0] a, b, res;
  logic [7:0]   fin, fout;
  logic [3:0]   op;
  int           total = 0;
  int           bad   = 0;
  int           cyc   = 0;
  bit           done  = 0;

  alu8_core #(.WIDTH(W)) u_alu8_core (
    .a_i(a), .b_i(b), .flags_i(fin), .op_i(op),
    .result_o(res), .flags_o(fout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad  = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input string req, input logic [3:0] o, input logic [7:0] av,
                     input logic [7:0] bv, input logic [7:0] fv,
                     input logic [7:0] er, input logic [7:0] ef);
    @(negedge clk);
    op = o; a = av; b = bv; fin = fv;
    #1;
    total++;
    if (res !== er || fout !== ef) begin
      bad++;
      $display("FAIL %s op=%h a=%h b=%h f=%h: got res=%h flags=%h expected res=%h flags=%h",
               req, o, av, bv, fv, res, fout, er, ef);
    end
  endtask

  task automatic t_logic;  // R3
    run("R3", 4'h0, 8'h33, 8'h55, 8'h00, 8'h11, 8'h00);
    run("R3", 4'h0, 8'h33, 8'hcc, 8'h00, 8'h00, 8'h02);
    run("R3", 4'h0, 8'hff, 8'h88, 8'h41, 8'h88, 8'hC1);
    run("R3", 4'h1, 8'h33, 8'hcc, 8'h00, 8'hff, 8'h80);
    run("R3", 4'h2, 8'hff, 8'hff, 8'h00, 8'h00, 8'h02);
  endtask

  task automatic t_step;  // R4
    run("R4", 4'h5, 8'hff, 8'h00, 8'h01, 8'h00, 8'h03);
    run("R4", 4'h5, 8'h7f, 8'h00, 8'h00, 8'h80, 8'h80);
    run("R4", 4'h6, 8'h00, 8'h00, 8'h40, 8'hff, 8'hC0);
    run("R4", 4'h6, 8'h80, 8'h00, 8'h80, 8'h7f, 8'h00);
  endtask

  task automatic t_shift;  // R5 R6
    run("R5", 4'h7, 8'h80, 8'h00, 8'h00, 8'h00, 8'h03);
    run("R5", 4'h7, 8'h70, 8'h00, 8'h40, 8'he0, 8'hC0);
    run("R6", 4'h8, 8'h01, 8'h00, 8'h01, 8'h80, 8'h81);
    run("R6", 4'h8, 8'h11, 8'h00, 8'h00, 8'h08, 8'h01);
    run("R6", 4'h8, 8'h00, 8'h00, 8'h01, 8'h80, 8'h80);
  endtask

  task automatic t_adc;  // R7
    run("R7", 4'h3, 8'h80, 8'h80, 8'h00, 8'h00, 8'h43);
    run("R7", 4'h3, 8'h7f, 8'h02, 8'h00, 8'h81, 8'hC0);
    run("R7", 4'h3, 8'h0d, 8'hd3, 8'h01, 8'he1, 8'h80);
    run("R7", 4'h3, 8'hbe, 8'hbf, 8'h00, 8'h7d, 8'h41);
  endtask

  task automatic t_sbc;  // R8
    run("R8", 4'h4, 8'h05, 8'h03, 8'h00, 8'h02, 8'h01);
    run("R8", 4'h4, 8'h05, 8'h03, 8'h01, 8'h02, 8'h01);
    run("R8", 4'h4, 8'h05, 8'h06, 8'h01, 8'hff, 8'h80);
    run("R8", 4'h4, 8'h80, 8'h01, 8'h00, 8'h7f, 8'h41);
  endtask

  task automatic t_cmp;  // R9
    run("R9", 4'h9, 8'h55, 8'h33, 8'h00, 8'h55, 8'h00);
    run("R9", 4'h9, 8'h33, 8'h55, 8'h00, 8'h33, 8'h81);
    run("R9", 4'h9, 8'h33, 8'h33, 8'h41, 8'h33, 8'h42);
  endtask

  task automatic t_bit;  // R10
    run("R10", 4'hA, 8'h55, 8'h22, 8'h00, 8'h55, 8'h02);
    run("R10", 4'hA, 8'hc0, 8'hc0, 8'h00, 8'hc0, 8'hC0);
    run("R10", 4'hA, 8'h55, 8'h33, 8'hC0, 8'h55, 8'h00);
    run("R10", 4'hA, 8'hff, 8'h40, 8'h01, 8'hff, 8'h41);
  endtask

  task automatic t_hold;  // R11 R12
    run("R11", 4'hB, 8'hff, 8'h12, 8'h80, 8'hff, 8'h80);
    run("R11", 4'hB, 8'h3c, 8'h00, 8'h7E, 8'h3c, 8'h7E);
    run("R12", 4'hC, 8'h5a, 8'h77, 8'hBD, 8'h00, 8'hBD);
    run("R12", 4'hF, 8'hff, 8'hff, 8'h42, 8'h00, 8'h42);
  endtask

  task automatic t_spare;  // R1 R2
    run("R1", 4'h0, 8'h33, 8'h55, 8'h3C, 8'h11, 8'h3C);
    run("R1", 4'h3, 8'h80, 8'h80, 8'h3C, 8'h00, 8'h7F);
    run("R2", 4'h8, 8'h02, 8'h00, 8'h3D, 8'h81, 8'hBC);
  endtask

  initial begin
    a = '0; b = '0; fin = '0; op = 4'hB;
    // reset-like idle state: THA with zero inputs is inert
    #1;
    total++;
    if (res !== 8'h00 || fout !== 8'h00) begin
      bad++;
      $display("FAIL R11 idle: got res=%h flags=%h expected res=00 flags=00", res, fout);
    end
    t_logic();
    t_step();
    t_shift();
    t_adc();
    t_sbc();
    t_cmp();
    t_bit();
    t_hold();
    t_spare();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule